// File: doc/BRIEF.md
# Self-Correcting One-Hot Phase Ring

This block produces the ordered phase strobes that step a successive approximation controller through its bit decisions. It is a ring of flip-flops in which a single active bit travels from the first stage to the last, one stage per enabled clock, and then starts again at the first stage. The last stage doubles as the end-of-conversion strobe, so a result register downstream can capture the finished answer on that cycle.

The first stage is not loaded from the last stage. It is loaded with the NOR of every stage except the last. A new token therefore enters only when the ring would otherwise be empty, apart from the last stage. This makes the ring start by itself from an all-zero state, put back a token that was lost, and let surplus tokens drain out before a new one is admitted. From any of the 2^N possible contents the ring settles into a clean single-token cycle within N enabled clocks.

An active-low reset clears every stage. It is asserted asynchronously and is expected to be released in step with the clock. An enable input freezes the ring while it is low.

Top module: `phase_ring_seq`

## Requirements
- R1: While `rst_n` is low, every bit of `phase` and `eoc` is 0.
- R2: On each rising clock edge with `en` high, stage k (`phase[k]`, for k from 1 to N-1) takes the value that stage k-1 held before the edge.
- R3: On each rising clock edge with `en` high, stage 0 (`phase[0]`, the first strobe) becomes 1 exactly when `phase[N-2:0]` is all zero before the edge. The last stage `phase[N-1]` has no influence on this decision.
- R4: From an all-zero ring, including the first enabled edge after reset is released, the next enabled edge makes `phase` equal to 1 (only bit 0 set).
- R5: While `en` is low, `phase` holds its value across clock edges.
- R6: `eoc` always equals the last stage `phase[N-1]`. In steady operation it is high for one clock in every N enabled clocks.
- R7: Once exactly one stage is high, it stays exactly one after every enabled edge. From any starting contents, exactly one stage is high after at most N enabled edges, with N = 8 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| en | input | 1 | Advance enable; when low the ring holds |
| phase | output | STAGES | Stage values; bit 0 is the first strobe, bit STAGES-1 the last |
| eoc | output | 1 | End-of-conversion strobe; copy of the last stage |

## Verification
The main function is first driven from a clean reset with the enable held high. This shows that the token appears in stage 0 one clock after release and walks to the last stage, with `eoc` rising only there. A run with the enable pulled low partway through the walk separates a true hold from a shift that is merely slow. The ring is then loaded with each of the 256 possible contents and stepped against an independent next-state model. Contents with only the last bit set show that the last stage is ignored by the feedback. Contents with many bits set show the drain of surplus tokens, and the all-zero contents show injection. After eight steps every one of these runs must show exactly one active stage.

// File: rtl/phase_ring_pkg.sv
package phase_ring_pkg;
  localparam int unsigned RING_STAGES_DEFAULT = 8;
  localparam int unsigned RING_STAGES_MIN     = 2;
endpackage

// File: rtl/ring_inject.sv
module ring_inject #(
  parameter int unsigned STAGES = phase_ring_pkg::RING_STAGES_DEFAULT,
  localparam int unsigned WATCH = STAGES - 1
) (
  input  logic [WATCH-1:0] watch_i,
  output logic             inject_o
);
  logic [WATCH:0] any_chain;

  assign any_chain[0] = 1'b0;
  for (genvar i = 0; i < WATCH; i++) begin : g_or
    assign any_chain[i+1] = any_chain[i] | watch_i[i];
  end

  assign inject_o = ~any_chain[WATCH];
endmodule

// File: rtl/ring_stage_reg.sv
module ring_stage_reg #(
  parameter int unsigned STAGES = phase_ring_pkg::RING_STAGES_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              inject_i,
  output logic [STAGES-1:0] stage_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = stage_q;
    if (en) begin
      stage_d[0] = inject_i;
      for (int k = 1; k < STAGES; k++) begin
        stage_d[k] = stage_q[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (en) begin
      stage_q <= stage_d;
    end
  end

  assign stage_o = stage_q;

  // R1: ring is empty while reset is held
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (stage_q == '0));

  // R2: every stage past the first copies its predecessor on an enabled edge
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (stage_q[STAGES-1:1] == $past(stage_q[STAGES-2:0])));

  // R3: a token enters when the watched stages are empty
  assert_inject_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (stage_q[STAGES-2:0] == '0)) |=> stage_q[0]);

  // R3: no token enters while any watched stage is set
  assert_no_inject_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (stage_q[STAGES-2:0] != '0)) |=> !stage_q[0]);

  // R4: an all-zero ring restarts with only the first stage set
  assert_restart_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (stage_q == '0)) |=> (stage_q == STAGES'(1)));

  // R7: a single token stays single
  assert_single_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $onehot(stage_q)) |=> $onehot(stage_q));
endmodule

// File: rtl/phase_ring_seq.sv
module phase_ring_seq #(
  parameter int unsigned STAGES = phase_ring_pkg::RING_STAGES_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [STAGES-1:0] phase,
  output logic              eoc
);
  localparam int unsigned LAST = STAGES - 1;

  logic              inject;
  logic [STAGES-1:0] stages;

  ring_inject #(.STAGES(STAGES)) u_inject (
    .watch_i  (stages[LAST-1:0]),
    .inject_o (inject)
  );

  ring_stage_reg #(.STAGES(STAGES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .inject_i (inject),
    .stage_o  (stages)
  );

  assign phase = stages;
  assign eoc   = stages[LAST];

  initial begin
    assert_stage_count_R7: assert (STAGES >= phase_ring_pkg::RING_STAGES_MIN);
  end
endmodule

// File: tb/sim_phase_ring_seq.sv
module sim_phase_ring_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic         en;
  logic [N-1:0] phase;
  logic         eoc;

  int n_tests;
  int n_fail;

  phase_ring_seq #(.STAGES(N)) u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .phase (phase),
    .eoc   (eoc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] model_next(input logic [N-1:0] s);
    return {s[N-2:0], ~|s[N-2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    en = 1'b1;
    repeat (3) tick();
    check(phase == '0, "R1 phase under reset", phase, '0);
    check(eoc == 1'b0, "R1 eoc under reset", {7'b0, eoc}, '0);
  endtask

  task automatic t_startup_cycle;
    logic [N-1:0] exp;
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check(phase == 8'b0000_0001, "R4 first strobe after release", phase, 8'b0000_0001);
    exp = 8'b0000_0001;
    for (int i = 1; i < N; i++) begin
      tick();
      exp = exp << 1;
      check(phase == exp, "R2 token walk", phase, exp);
      check(eoc == (i == N-1), "R6 eoc only at last stage", {7'b0, eoc},
            {7'b0, 1'(i == N-1)});
    end
    tick();
    check(phase == 8'b0000_0001, "R3 wrap back to first stage", phase, 8'b0000_0001);
  endtask

  task automatic t_hold;
    logic [N-1:0] held;
    tick();
    tick();
    @(negedge clk);
    en = 1'b0;
    held = phase;
    repeat (4) begin
      tick();
      check(phase == held, "R5 hold with enable low", phase, held);
    end
    @(negedge clk);
    en = 1'b1;
    tick();
    check(phase == model_next(held), "R5 resume after hold", phase, model_next(held));
  endtask

  task automatic t_recover_all;
    logic [N-1:0] exp;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      force u0.u_regs.stage_q = 8'(v);
      #1;
      release u0.u_regs.stage_q;
      check(phase == 8'(v), "R7 loaded state visible", phase, 8'(v));
      @(negedge clk);
      en = 1'b1;
      exp = 8'(v);
      for (int s = 0; s < N; s++) begin
        tick();
        exp = model_next(exp);
        if (phase != exp) begin
          check(1'b0, "R3 next-state from loaded ring", phase, exp);
        end
      end
      check(phase == exp, "R7 state after eight steps", phase, exp);
      check($countones(phase) == 1, "R7 single token within eight steps", phase, exp);
      check(eoc == phase[N-1], "R6 eoc tracks last stage", {7'b0, eoc}, {7'b0, phase[N-1]});
    end
  endtask

  initial begin
    n_tests = 0;
    n_fail = 0;
    rst_n = 1'b0;
    en = 1'b0;
    t_reset();
    t_startup_cycle();
    t_hold();
    t_recover_all();
    t_reset();
    check(phase == '0, "R1 reset mid-run", phase, '0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule